// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block derives sixteen bank clocks and one feedback clock from a single source clock. The source is either a fast internal clock or, in bypass, one of two reference inputs: an external reference or an oscillator reference. Each of four banks has its own divide select and its own output-enable. The feedback output has a separate select with a different ratio set. A master reset holds every divider at the start of its period and forces all clock outputs low.

Every divider counts on the same source clock and leaves reset on the same rising edge. Outputs that share a ratio therefore stay in phase. The odd ratio uses a falling-edge stage so that its duty cycle stays at 50%. A change of select is applied only where a period ends. High impedance is modelled by a per-bank drive-enable output that sits beside the clock values. The clocks and enables are plain control-style pins with no valid/ready flow, since no data stream crosses the block.

Top module: `mbank_clk_divider`

## Requirements
- R1: Bank b takes its ratio from `bank_sel_i[2b+1:2b]`, coded 00 = ÷3, 01 = ÷4, 10 = ÷6, 11 = ÷12. All four bits `bank_clk_o[4b+3:4b]` carry the same waveform.
- R2: The feedback ratio comes from `fb_sel_i`, coded 00 = ÷6, 01 = ÷12, 10 = ÷16, 11 = ÷20. It drives `fb_clk_o`.
- R3: While `mrst_i` is high, every bit of `bank_clk_o` and `fb_clk_o` is low.
- R4: After `mrst_i` falls, each divider's first period begins at the next rising source edge. For an even ratio N the output is high for N/2 source cycles and then low for N/2. For ÷3 it is high from that rising edge until the falling edge of the following cycle (1.5 cycles), then low for 1.5 cycles.
- R5: `bank_drv_en_o[b]` follows `bank_oe_i[b]` whatever the level of `mrst_i`. A disabled bank's divider keeps counting, so re-enabling it shows the same phase as if it had never been disabled.
- R6: With `use_pll_i` high the dividers count the fast clock. With it low they count the selected reference, so each output runs at that reference divided by its ratio.
- R7: In bypass, `use_xtal_i` high selects `ref_xtal_i` and low selects `ref_ext_i`.
- R8: A change of a divide select made during a period does not affect that period. The new ratio takes effect from the next rising edge at which a period starts.
- R9: A bank and the feedback output set to the same ratio have identical waveforms after a common reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast internal clock |
| ref_ext_i | input | 1 | External reference clock |
| ref_xtal_i | input | 1 | Oscillator reference clock |
| use_pll_i | input | 1 | 1 = fast clock, 0 = bypass to reference |
| use_xtal_i | input | 1 | Reference choice in bypass: 1 = oscillator, 0 = external |
| mrst_i | input | 1 | Master reset, active high, asynchronous |
| bank_sel_i | input | 8 | Per-bank divide selects, two bits per bank |
| bank_oe_i | input | 4 | Per-bank output enable |
| fb_sel_i | input | 2 | Feedback divide select |
| bank_clk_o | output | 16 | Bank clocks, four per bank, bank b at bits 4b+3..4b |
| bank_drv_en_o | output | 4 | Per-bank drive enable (0 = high impedance) |
| fb_clk_o | output | 1 | Feedback clock |

## Verification
Each divider output changes at a rising edge of the source clock. The ÷3 output also changes at a falling edge, so every result is due within the same half-cycle as the edge that causes it. The bench holds a per-divider model of the period position and ratio, and steps it at every rising edge of the clock that the selects should route. It samples 2 ns after each rising edge and 2 ns after each falling edge, which checks both halves of every cycle, including the half-cycle step of ÷3. Select and enable changes are applied only just after a sampled falling edge. This places a mid-period change at a known model position, so the R8 boundary is predicted exactly.

// File: rtl/mbdiv_pkg.sv
package mbdiv_pkg;
  localparam int unsigned SEL_W = 2;
  typedef logic [SEL_W-1:0] div_sel_t;
  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_FAST = 2'd2
  } clk_src_e;
endpackage

// File: rtl/mbdiv_src_mux.sv
module mbdiv_src_mux
  import mbdiv_pkg::*;
(
  input  logic fast_i,
  input  logic ext_i,
  input  logic xtal_i,
  input  logic use_pll_i,
  input  logic use_xtal_i,
  output logic src_clk_o
);
  clk_src_e src;

  always_comb begin
    if (use_pll_i)       src = SRC_FAST;
    else if (use_xtal_i) src = SRC_XTAL;
    else                 src = SRC_EXT;
  end

  always_comb begin
    case (src)
      SRC_FAST: src_clk_o = fast_i;
      SRC_XTAL: src_clk_o = xtal_i;
      default:  src_clk_o = ext_i;
    endcase
  end
endmodule

// File: rtl/mbdiv_ratio_div.sv
module mbdiv_ratio_div
  import mbdiv_pkg::*;
#(
  parameter int unsigned R0 = 3,
  parameter int unsigned R1 = 4,
  parameter int unsigned R2 = 6,
  parameter int unsigned R3 = 12
) (
  input  logic     clk_i,
  input  logic     rst_i,
  input  div_sel_t sel_i,
  output logic     div_o
);
  localparam int unsigned RMAX_LO = (R0 > R1) ? R0 : R1;
  localparam int unsigned RMAX_HI = (R2 > R3) ? R2 : R3;
  localparam int unsigned RMAX    = (RMAX_LO > RMAX_HI) ? RMAX_LO : RMAX_HI;
  localparam int unsigned CW      = $clog2(RMAX + 1);
  localparam bit          HAS_ODD = ((R0 % 2) + (R1 % 2) + (R2 % 2) + (R3 % 2)) != 0;

  function automatic logic [CW-1:0] ratio_of(input div_sel_t s);
    case (s)
      2'd0:    return CW'(R0);
      2'd1:    return CW'(R1);
      2'd2:    return CW'(R2);
      default: return CW'(R3);
    endcase
  endfunction

  logic [CW-1:0] cnt_q, cur_n_q, eff_n, half_n;
  logic          armed_q, hi_q, hi_n_q, wrap;

  // Until the first edge after reset the select is used directly.
  assign eff_n  = armed_q ? cur_n_q : ratio_of(sel_i);
  assign half_n = eff_n >> 1;
  assign wrap   = (cnt_q == eff_n - CW'(1));

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      cur_n_q <= '0;
      armed_q <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      cnt_q   <= wrap ? '0 : cnt_q + CW'(1);
      hi_q    <= (cnt_q < half_n);
      armed_q <= 1'b1;
      if (!armed_q || wrap) cur_n_q <= ratio_of(sel_i);
    end
  end

  generate
    if (HAS_ODD) begin : g_odd
      always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) hi_n_q <= 1'b0;
        else       hi_n_q <= hi_q;
      end
    end else begin : g_even
      assign hi_n_q = 1'b0;
    end
  endgenerate

  assign div_o = hi_q | (eff_n[0] & hi_n_q);

  // R3: reset forces the output low
  always @(negedge clk_i) begin
    if (rst_i) begin
      a_r3_low_in_reset: assert (!div_o) else $error("divider output high in reset");
    end
  end

  // R4: period position never reaches the active ratio
  a_r4_cnt_in_range: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < eff_n) else $error("count out of range");

  // R4: output high phase begins only at the start of a period
  a_r4_rise_at_start: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hi_q) |-> (cnt_q == CW'(1))) else $error("rise away from period start");

  // R8: the active ratio is frozen inside a period
  a_r8_hold_mid_period: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_q && $past(armed_q) && cnt_q != '0) |-> $stable(cur_n_q))
    else $error("ratio changed mid-period");
endmodule

// File: rtl/mbank_clk_divider.sv
module mbank_clk_divider
  import mbdiv_pkg::*;
#(
  parameter int unsigned NUM_BANKS     = 4,
  parameter int unsigned OUTS_PER_BANK = 4,
  parameter int unsigned BANK_R0 = 3,
  parameter int unsigned BANK_R1 = 4,
  parameter int unsigned BANK_R2 = 6,
  parameter int unsigned BANK_R3 = 12,
  parameter int unsigned FB_R0   = 6,
  parameter int unsigned FB_R1   = 12,
  parameter int unsigned FB_R2   = 16,
  parameter int unsigned FB_R3   = 20
) (
  input  logic                                 clk_fast_i,
  input  logic                                 ref_ext_i,
  input  logic                                 ref_xtal_i,
  input  logic                                 use_pll_i,
  input  logic                                 use_xtal_i,
  input  logic                                 mrst_i,
  input  logic [NUM_BANKS*SEL_W-1:0]           bank_sel_i,
  input  logic [NUM_BANKS-1:0]                 bank_oe_i,
  input  logic [SEL_W-1:0]                     fb_sel_i,
  output logic [NUM_BANKS*OUTS_PER_BANK-1:0]   bank_clk_o,
  output logic [NUM_BANKS-1:0]                 bank_drv_en_o,
  output logic                                 fb_clk_o
);
  logic src_clk;

  mbdiv_src_mux u_src (
    .fast_i     (clk_fast_i),
    .ext_i      (ref_ext_i),
    .xtal_i     (ref_xtal_i),
    .use_pll_i  (use_pll_i),
    .use_xtal_i (use_xtal_i),
    .src_clk_o  (src_clk)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic div_w;
      mbdiv_ratio_div #(.R0(BANK_R0), .R1(BANK_R1), .R2(BANK_R2), .R3(BANK_R3)) u_div (
        .clk_i (src_clk),
        .rst_i (mrst_i),
        .sel_i (bank_sel_i[b*SEL_W +: SEL_W]),
        .div_o (div_w)
      );
      assign bank_clk_o[b*OUTS_PER_BANK +: OUTS_PER_BANK] = {OUTS_PER_BANK{div_w}};
    end
  endgenerate

  mbdiv_ratio_div #(.R0(FB_R0), .R1(FB_R1), .R2(FB_R2), .R3(FB_R3)) u_fb (
    .clk_i (src_clk),
    .rst_i (mrst_i),
    .sel_i (fb_sel_i),
    .div_o (fb_clk_o)
  );

  // Drive enable is independent of reset; the dividers keep running.
  assign bank_drv_en_o = bank_oe_i;
endmodule

// File: tb/tb_mbank_clk_divider.sv
module tb_mbank_clk_divider;
  logic clk = 1'b0, ref_ext = 1'b0, ref_xtal = 1'b0;
  always #5  clk      = ~clk;
  always #12 ref_ext  = ~ref_ext;
  always #18 ref_xtal = ~ref_xtal;

  logic       use_pll = 1'b1, use_xtal = 1'b0, mrst = 1'b1;
  logic [7:0] bsel = 8'h00;
  logic [3:0] boe  = 4'hF;
  logic [1:0] fsel = 2'b00;
  wire [15:0] bclk;
  wire [3:0]  den;
  wire        fclk;

  mbank_clk_divider dut (
    .clk_fast_i(clk), .ref_ext_i(ref_ext), .ref_xtal_i(ref_xtal),
    .use_pll_i(use_pll), .use_xtal_i(use_xtal), .mrst_i(mrst),
    .bank_sel_i(bsel), .bank_oe_i(boe), .fb_sel_i(fsel),
    .bank_clk_o(bclk), .bank_drv_en_o(den), .fb_clk_o(fclk)
  );

  // Clock the requirements say should be routed (R6, R7)
  wire cur_clk = use_pll ? clk : (use_xtal ? ref_xtal : ref_ext);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mN[5], mp[5];
  bit e1[5], e2[5];
  bit fresh = 1, r9_on = 0;

  function automatic int bank_ratio(input logic [1:0] s);
    case (s) 2'd0: return 3; 2'd1: return 4; 2'd2: return 6; default: return 12; endcase
  endfunction
  function automatic int fb_ratio(input logic [1:0] s);
    case (s) 2'd0: return 6; 2'd1: return 12; 2'd2: return 16; default: return 20; endcase
  endfunction
  function automatic int sel_ratio(input int d);
    return (d < 4) ? bank_ratio(bsel[2*d +: 2]) : fb_ratio(fsel);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs(input bit second, input string tag);
    for (int d = 0; d < 4; d++) begin
      logic [3:0] exp4;
      exp4 = {4{second ? e2[d] : e1[d]}};
      chk(bclk[4*d +: 4] == exp4, tag, int'(bclk[4*d +: 4]), int'(exp4));
      if (r9_on && mN[d] == mN[4])
        chk(bclk[4*d] == fclk, "R9", int'(bclk[4*d]), int'(fclk));
    end
    chk(fclk == (second ? e2[4] : e1[4]), tag, int'(fclk), int'(second ? e2[4] : e1[4]));
    chk(den == boe, "R5", int'(den), int'(boe));
  endtask

  task automatic run(input int cyc, input string tag);
    repeat (cyc) begin
      @(posedge cur_clk);
      for (int d = 0; d < 5; d++) begin
        if (fresh) mN[d] = sel_ratio(d);
        e1[d] = (2*mp[d] < mN[d]);
        e2[d] = (2*mp[d] + 1 < mN[d]);
        if (mp[d] == mN[d] - 1) begin
          mp[d] = 0;
          mN[d] = sel_ratio(d);
        end else mp[d]++;
      end
      fresh = 0;
      #2 check_outs(1'b0, tag);
      @(negedge cur_clk);
      #2 check_outs(1'b1, tag);
    end
  endtask

  task automatic start(input bit pll, input bit xt, input logic [7:0] bs, input logic [1:0] fs);
    mrst = 1'b1;
    #1;
    use_pll = pll; use_xtal = xt; bsel = bs; fsel = fs;
    for (int d = 0; d < 5; d++) mp[d] = 0;
    fresh = 1;
    repeat (3) begin
      @(posedge cur_clk);
      #2;
      chk(bclk == 16'h0, "R3", int'(bclk), 0);
      chk(fclk == 1'b0, "R3", int'(fclk), 0);
      chk(den == boe, "R5", int'(den), int'(boe));
    end
    @(negedge cur_clk);
    #2 mrst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..R9 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // Sweep: rotate every select value across the banks and the feedback path
    for (int v = 0; v < 4; v++) begin
      logic [7:0] bs;
      for (int b = 0; b < 4; b++) bs[2*b +: 2] = 2'((v + b) % 4);
      start(1'b1, 1'b0, bs, 2'(v));
      r9_on = 1;
      run(62, "R1 R2 R4");
      r9_on = 0;
    end
    // Bypass through each reference
    start(1'b0, 1'b0, 8'b11_10_01_00, 2'b00);
    run(30, "R6 R7");
    start(1'b0, 1'b1, 8'b00_01_10_11, 2'b01);
    run(30, "R6 R7");
    // Select changes in the middle of a period
    start(1'b1, 1'b0, 8'h55, 2'b00);
    run(5, "R8");
    bsel = 8'b00_11_10_00; fsel = 2'b11;
    run(60, "R8");
    bsel = 8'hAA; fsel = 2'b10;
    run(3, "R8");
    bsel = 8'h00; fsel = 2'b01;
    run(40, "R8");
    // Output enables, while running and while in reset
    boe = 4'b0101;
    run(20, "R5");
    boe = 4'b1010;
    start(1'b1, 1'b0, 8'b01_01_10_10, 2'b00);
    run(20, "R5");
    boe = 4'hF;
    run(20, "R5");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule